// File: doc/BRIEF.md
# Special Request Capture for a Microcoded Decoder

This block sits in front of the instruction decoder of a microcoded processor and holds four kinds of pending request: a reset request, a non-maskable interrupt, a maskable interrupt, and a set-overflow request. Each request has its own flag. The microcode clears the flags through a small encoded clear field. A request is never lost between the moment it arrives and the moment the microcode acknowledges it.

At the load strobe of step one of every instruction, the block takes a snapshot of the four flags. In the same cycle it records whether any flag was set. That recorded bit drives the decoder-input multiplexer. When it is set, the decoder sees the snapshot bits instead of the opcode, so the microcode runs the matching service sequence. When it is clear, the opcode passes through unchanged. All inputs are sampled on the block clock.

Top module: `special_req_capture`

## Requirements
- R1: After `rst_ni` is released, and before any step-one strobe, `special_o` is 0 and `dec_bus_o` equals `opcode_i`.
- R2: A high-to-low transition on `nmi_ni` sets the NMI flag. A `nmi_ni` that stays low after its flag has been cleared does not set the flag again.
- R3: The maskable-interrupt flag is set in a cycle where `irq_sample_i` is 1, `irq_ni` is 0 and `irq_dis_i` is 0. It is not set when `irq_dis_i` is 1 or when `irq_sample_i` is 0.
- R4: A high-to-low transition on `so_ni` sets the set-overflow flag, with the same edge-only behaviour as R2.
- R5: The reset flag is set whenever `rst_req_ni` is low. It cannot be cleared while `rst_req_ni` stays low.
- R6: When `clr_en_i` is 1, clear code 0 clears both the reset flag and the set-overflow flag, code 2 clears the NMI flag, and code 3 clears the maskable-interrupt flag. Codes 1 and 4 to 7, and any code while `clr_en_i` is 0, change no flag.
- R7: At a cycle with `step1_i` high, the flags are snapshotted. While the snapshot is selected, `dec_bus_o` carries reset in bit 0, set-overflow in bit 1, NMI in bit 2 and maskable interrupt in bit 3, with all higher bits at 0.
- R8: `special_o` changes only at a step-one strobe. It is 1 exactly when any flag was set at that strobe. While it is 1, `dec_bus_o` holds the snapshot regardless of later flag or opcode changes.
- R9: A setting event in the same cycle as its own clear code leaves the flag set.
- R10: With no explicit clear of the select bit, the first step-one strobe after all flags are cleared returns `dec_bus_o` to `opcode_i` and `special_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rst_req_ni | input | 1 | Reset request, active low, level |
| nmi_ni | input | 1 | Non-maskable interrupt, falling-edge |
| irq_ni | input | 1 | Maskable interrupt, active low, level |
| so_ni | input | 1 | Set-overflow request, falling-edge |
| irq_dis_i | input | 1 | Interrupt-disable flag state |
| irq_sample_i | input | 1 | End-of-phase sampling strobe for `irq_ni` |
| clr_en_i | input | 1 | Clear field valid |
| clr_code_i | input | CODE_W | Encoded clear select |
| step1_i | input | 1 | Step-one load strobe |
| opcode_i | input | OP_W | Instruction register contents |
| dec_bus_o | output | OP_W | Decoder input: opcode or request snapshot |
| special_o | output | 1 | Snapshot selected instead of opcode |

## Verification
The hardest conditions to reach are the collisions. One is a falling edge that lands in the very cycle its clear code is issued. The other is a reset request still held low while its clear fires. In both cases only the next strobed snapshot shows whether the flag survived. The stimulus therefore drives the edge and the clear on the same clock edge, or keeps the reset request low across the clear, and then strobes step one. A sweep covers all sixteen request combinations with interrupts both enabled and disabled. After each combination it clears every flag and strobes again to confirm the return to the opcode path.

// File: rtl/special_req_pkg.sv
package special_req_pkg;
  localparam int NUM_SRC = 4;
  // snapshot bit positions, decoded by the microcode
  localparam int SRC_RST = 0;
  localparam int SRC_SO  = 1;
  localparam int SRC_NMI = 2;
  localparam int SRC_IRQ = 3;
  // clear field codes
  localparam int CLR_RST_SO = 0;
  localparam int CLR_NMI    = 2;
  localparam int CLR_IRQ    = 3;
endpackage

// File: rtl/req_clr_decode.sv
module req_clr_decode
  import special_req_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [NUM_SRC-1:0] clr_o
);
  logic hit_rst_so, hit_nmi, hit_irq;

  always_comb begin
    hit_rst_so = en_i && (code_i == CODE_W'(CLR_RST_SO));
    hit_nmi    = en_i && (code_i == CODE_W'(CLR_NMI));
    hit_irq    = en_i && (code_i == CODE_W'(CLR_IRQ));
  end

  always_comb begin
    clr_o          = '0;
    clr_o[SRC_RST] = hit_rst_so;
    clr_o[SRC_SO]  = hit_rst_so;   // shared clear line
    clr_o[SRC_NMI] = hit_nmi;
    clr_o[SRC_IRQ] = hit_irq;
  end
endmodule

// File: rtl/req_edge_flag.sv
module req_edge_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  input  logic clr_i,
  output logic flag_o
);
  logic prev_q, flag_q, fall;

  assign fall = prev_q & ~pin_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      prev_q <= pin_ni;
      if (fall)       flag_q <= 1'b1;   // set wins over clear
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/req_level_flag.sv
module req_level_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (set_i)   flag_q <= 1'b1;
    else if (clr_i)   flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/req_snapshot.sv
module req_snapshot
  import special_req_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [OP_W-1:0]    opcode_i,
  output logic [OP_W-1:0]    bus_o,
  output logic               sel_o
);
  localparam int PAD_W = OP_W - NUM_SRC;

  logic [NUM_SRC-1:0] snap_q;
  logic               sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= '0;
      sel_q  <= 1'b0;
    end else if (load_i) begin
      snap_q <= req_i;
      sel_q  <= |req_i;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign bus_o = sel_q ? {{PAD_W{1'b0}}, snap_q} : opcode_i;
    end else begin : g_nopad
      assign bus_o = sel_q ? snap_q : opcode_i;
    end
  endgenerate

  assign sel_o = sel_q;
endmodule

// File: rtl/special_req_capture.sv
module special_req_capture
  import special_req_pkg::*;
#(
  parameter int OP_W   = 8,
  parameter int CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rst_req_ni,
  input  logic              nmi_ni,
  input  logic              irq_ni,
  input  logic              so_ni,
  input  logic              irq_dis_i,
  input  logic              irq_sample_i,
  input  logic              clr_en_i,
  input  logic [CODE_W-1:0] clr_code_i,
  input  logic              step1_i,
  input  logic [OP_W-1:0]   opcode_i,
  output logic [OP_W-1:0]   dec_bus_o,
  output logic              special_o
);
  localparam int EDGE_N = 2;

  logic [NUM_SRC-1:0] clr;
  logic [NUM_SRC-1:0] req_q;
  logic [EDGE_N-1:0]  edge_pin_n;
  logic               irq_set;

  req_clr_decode #(.CODE_W(CODE_W)) u_clr (
    .en_i   (clr_en_i),
    .code_i (clr_code_i),
    .clr_o  (clr)
  );

  assign edge_pin_n = {nmi_ni, so_ni};

  for (genvar g = 0; g < EDGE_N; g++) begin : g_edge
    localparam int IDX = (g == 0) ? SRC_SO : SRC_NMI;
    req_edge_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_ni (edge_pin_n[g]),
      .clr_i  (clr[IDX]),
      .flag_o (req_q[IDX])
    );
  end

  assign irq_set = irq_sample_i & ~irq_ni & ~irq_dis_i;

  req_level_flag u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (irq_set),
    .clr_i  (clr[SRC_IRQ]),
    .flag_o (req_q[SRC_IRQ])
  );

  // reset request dominates its clear while held low
  req_level_flag u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (~rst_req_ni),
    .clr_i  (clr[SRC_RST]),
    .flag_o (req_q[SRC_RST])
  );

  req_snapshot #(.OP_W(OP_W)) u_snap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (step1_i),
    .req_i    (req_q),
    .opcode_i (opcode_i),
    .bus_o    (dec_bus_o),
    .sel_o    (special_o)
  );
endmodule

// File: rtl/special_req_capture_chk.sv
module special_req_capture_chk
  import special_req_pkg::*;
#(
  parameter int OP_W   = 8,
  parameter int CODE_W = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rst_req_ni,
  input logic               nmi_ni,
  input logic               irq_ni,
  input logic               irq_dis_i,
  input logic               irq_sample_i,
  input logic               clr_en_i,
  input logic [CODE_W-1:0]  clr_code_i,
  input logic               step1_i,
  input logic [OP_W-1:0]    dec_bus_o,
  input logic               special_o,
  input logic [NUM_SRC-1:0] req_q
);
  // R8: select only moves at a strobe
  a_r8_sel_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step1_i |=> $stable(special_o));

  // R7: selected bus carries a nonzero snapshot in the low bits only
  a_r7_snap_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    special_o |-> (dec_bus_o[OP_W-1:NUM_SRC] == '0) && (dec_bus_o[NUM_SRC-1:0] != '0));

  // R5: reset request level always leaves the flag set
  a_r5_rst_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_req_ni |=> req_q[SRC_RST]);

  // R3: maskable flag only rises after an enabled low sample
  a_r3_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q[SRC_IRQ]) |-> $past(irq_sample_i && !irq_ni && !irq_dis_i));

  // R6: clear code 3 without a concurrent sample empties the flag
  a_r6_irq_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && clr_code_i == CODE_W'(CLR_IRQ) && !irq_sample_i) |=> !req_q[SRC_IRQ]);

  // R2: NMI flag rises only after a falling edge
  a_r2_nmi_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q[SRC_NMI]) |-> $past($fell(nmi_ni)));
endmodule

bind special_req_capture special_req_capture_chk #(.OP_W(OP_W), .CODE_W(CODE_W)) u_chk (.*);

// File: tb/special_req_capture_bench.sv
module special_req_capture_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rst_req_ni = 1'b1, nmi_ni = 1'b1, irq_ni = 1'b1, so_ni = 1'b1;
  logic       irq_dis_i = 1'b0, irq_sample_i = 1'b0, clr_en_i = 1'b0, step1_i = 1'b0;
  logic [2:0] clr_code_i = '0;
  logic [7:0] opcode_i = 8'hA9;
  logic [7:0] dec_bus_o;
  logic       special_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  special_req_capture u_special_req_capture (.*);

  task automatic tick(); @(negedge clk_i); endtask

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic nmi_pulse(); nmi_ni = 0; tick(); nmi_ni = 1; tick(); endtask
  task automatic so_pulse();  so_ni = 0;  tick(); so_ni = 1;  tick(); endtask
  task automatic rst_pulse(); rst_req_ni = 0; tick(); rst_req_ni = 1; tick(); endtask
  task automatic irq_pulse();
    irq_ni = 0; irq_sample_i = 1; tick(); irq_sample_i = 0; irq_ni = 1; tick();
  endtask
  task automatic clear(int code);
    clr_en_i = 1; clr_code_i = 3'(code); tick(); clr_en_i = 0; tick();
  endtask
  task automatic clear_all(); clear(0); clear(2); clear(3); endtask
  task automatic strobe(); step1_i = 1; tick(); step1_i = 0; endtask

  initial begin
    tick(); tick(); rst_ni = 1; tick();
    chk("R1 bus", dec_bus_o, 8'hA9);
    chk("R1 sel", {7'd0, special_o}, 8'd0);

    // sweep every combination, interrupts enabled and disabled
    for (int dis = 0; dis < 2; dis++) begin
      for (int m = 0; m < 16; m++) begin
        logic [7:0] op, exp;
        op = 8'(m * 16 + dis * 3 + 1);
        opcode_i = op; irq_dis_i = dis[0];
        if (m[0]) rst_pulse();
        if (m[1]) so_pulse();
        if (m[2]) nmi_pulse();
        if (m[3]) irq_pulse();
        strobe();
        exp = 8'(m & (dis != 0 ? 7 : 15));
        chk("R7 snapshot (R2 R3 R4 R5)", dec_bus_o, (exp != 0) ? exp : op);
        chk("R8 select", {7'd0, special_o}, {7'd0, exp != 0});
        clear_all(); strobe();
        chk("R10 back to opcode", dec_bus_o, op);
        chk("R10 select low", {7'd0, special_o}, 8'd0);
      end
    end
    irq_dis_i = 0; opcode_i = 8'h3C;

    // R3: low level without the sampling strobe sets nothing
    irq_ni = 0; tick(); tick(); irq_ni = 1; tick(); strobe();
    chk("R3 no sample", dec_bus_o, 8'h3C);

    // R2: held-low NMI does not re-arm after clear
    nmi_ni = 0; tick(); tick(); strobe();
    chk("R2 edge sets", dec_bus_o, 8'h04);
    clear(2); tick(); strobe();
    chk("R2 held low no reset", dec_bus_o, 8'h3C);
    nmi_ni = 1; tick();

    // R4: held-low SO likewise
    so_ni = 0; tick(); tick(); strobe();
    chk("R4 edge sets", dec_bus_o, 8'h02);
    clear(0); strobe();
    chk("R4 held low no reset", dec_bus_o, 8'h3C);
    so_ni = 1; tick();

    // R5: reset request held across its clear
    rst_req_ni = 0; tick(); clear(0); strobe();
    chk("R5 held", dec_bus_o, 8'h01);
    rst_req_ni = 1; tick(); clear(0); strobe();
    chk("R5 released cleared", dec_bus_o, 8'h3C);

    // R6: unused codes and disabled field leave flags alone
    rst_pulse(); so_pulse(); nmi_pulse(); irq_pulse();
    clear(1); clear(4); clear(5); clear(6); clear(7);
    clr_code_i = 3'd2; tick(); tick();
    strobe();
    chk("R6 no-op codes", dec_bus_o, 8'h0F);
    clear(0); strobe();
    chk("R6 shared clear", dec_bus_o, 8'h0C);
    clear(2); strobe();
    chk("R6 nmi clear", dec_bus_o, 8'h08);
    clear(3); strobe();
    chk("R6 irq clear", dec_bus_o, 8'h3C);

    // R8: snapshot holds while flags and opcode move
    nmi_pulse(); strobe();
    clear(2); opcode_i = 8'hE7; tick();
    chk("R8 hold bus", dec_bus_o, 8'h04);
    chk("R8 hold sel", {7'd0, special_o}, 8'd1);
    strobe();
    chk("R10 after hold", dec_bus_o, 8'hE7);

    // R9: edge in the same cycle as its clear
    nmi_ni = 0; clr_en_i = 1; clr_code_i = 3'd2; tick();
    clr_en_i = 0; nmi_ni = 1; tick(); strobe();
    chk("R9 nmi set wins", dec_bus_o, 8'h04);
    clear(2);
    irq_ni = 0; irq_sample_i = 1; clr_en_i = 1; clr_code_i = 3'd3; tick();
    irq_sample_i = 0; irq_ni = 1; clr_en_i = 0; tick(); strobe();
    chk("R9 irq set wins", dec_bus_o, 8'h08);
    clear(3); strobe();
    chk("R10 final", dec_bus_o, 8'hE7);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule